// File: doc/BRIEF.md
# Aliased Set/Clear Control Register

This block is one 64-bit control word on a simple register bus. The bus gives a byte address, and the block turns it into a word offset by dropping the three low bits. Software can reach the word at three offsets. One offset overwrites the word. A second offset ANDs the write data into the current contents, which clears chosen bits in one access. A third offset ORs the write data in, which sets chosen bits. Only the top sixteen bits hold state. The lower part of the word always reads back as zero.

The most significant bit of the word drives an interrupt line to the host interrupt controller. Reads answer one cycle after the request. Only the direct offset returns the stored contents. An access to an offset that the block does not implement changes nothing and raises a one-cycle error pulse.

Top module: `misc_ctl_alias`

## Requirements
- R1: The word offset is the byte address shifted right by three. Address bits 2:0 have no effect on which offset is selected.
- R2: A write to offset 0x4020 replaces the stored value with the write data, after masking.
- R3: A write to offset 0x4021 stores the bitwise AND of the current value and the write data.
- R4: A write to offset 0x4022 stores the bitwise OR of the current value and the write data.
- R5: Only bits 63:48 are kept. Bits 47:0 of every read response are zero.
- R6: `irq_out` equals bit 63 of the stored value, where bit 63 is the most significant data bit. It takes its new value at the clock edge that accepts the write.
- R7: After reset the stored value is zero, and `irq_out`, `rsp_valid` and `err_unimpl` are low.
- R8: Every read raises `rsp_valid` for exactly one cycle, in the cycle after the request. A read of 0x4020 returns the stored value. A read of any other offset, including 0x4021 and 0x4022, returns zero.
- R9: A write to any offset other than 0x4020, 0x4021 and 0x4022 leaves the stored value unchanged.
- R10: `err_unimpl` is high for one cycle, in the cycle after an access (read or write) to an offset other than the three above. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte address |
| req_wdata | input | DATA_W (64) | Write data, bit 63 most significant |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W (64) | Read response data |
| err_unimpl | output | 1 | Access hit an unimplemented offset |
| irq_out | output | 1 | Interrupt, equal to stored bit 63 |

## Verification
Two functions can meet in the same cycle. A write that moves bit 63 changes `irq_out`, and in that same cycle a read issued right behind it must already return the merged value. The bench provokes this with a write followed at once by a read on the next cycle, through all three aliases and a randomized access stream. A behavioural model checks `irq_out`, the read data and the error pulse against its own expectations on every clock.

// File: rtl/misc_ctl_pkg.sv
package misc_ctl_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_DIRECT = 2'd1,
    TGT_CLR    = 2'd2,
    TGT_SET    = 2'd3
  } tgt_e;
endpackage

// File: rtl/misc_addr_dec.sv
module misc_addr_dec
  import misc_ctl_pkg::*;
#(
  parameter int unsigned OFS_W   = 17,
  parameter int unsigned DIR_OFS = 32'h4020,
  parameter int unsigned CLR_OFS = 32'h4021,
  parameter int unsigned SET_OFS = 32'h4022
) (
  input  logic [OFS_W-1:0] ofs_i,
  output tgt_e             tgt_o
);
  localparam logic [OFS_W-1:0] DIR_K = OFS_W'(DIR_OFS);
  localparam logic [OFS_W-1:0] CLR_K = OFS_W'(CLR_OFS);
  localparam logic [OFS_W-1:0] SET_K = OFS_W'(SET_OFS);

  always_comb begin
    tgt_o = TGT_NONE;
    if (ofs_i == DIR_K)      tgt_o = TGT_DIRECT;
    else if (ofs_i == CLR_K) tgt_o = TGT_CLR;
    else if (ofs_i == SET_K) tgt_o = TGT_SET;
  end
endmodule

// File: rtl/misc_store.sv
module misc_store
  import misc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  tgt_e              tgt_i,
  input  logic [KEEP_W-1:0] wdata_hi_i,
  output logic [DATA_W-1:0] word_o,
  output logic              irq_o
);
  localparam int unsigned LOW_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] keep_q;
  logic [KEEP_W-1:0] keep_d;
  logic              keep_en;

  always_comb begin
    keep_en = wr_en_i && (tgt_i != TGT_NONE);
    unique case (tgt_i)
      TGT_DIRECT: keep_d = wdata_hi_i;
      TGT_CLR:    keep_d = keep_q & wdata_hi_i;
      TGT_SET:    keep_d = keep_q | wdata_hi_i;
      default:    keep_d = keep_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       keep_q <= '0;
    else if (keep_en) keep_q <= keep_d;
  end

  assign word_o = {keep_q, {LOW_W{1'b0}}};
  assign irq_o  = keep_q[KEEP_W-1];

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && tgt_i == TGT_DIRECT) |=> word_o[DATA_W-1:LOW_W] == $past(wdata_hi_i));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && tgt_i == TGT_CLR) |=>
      word_o[DATA_W-1:LOW_W] == ($past(word_o[DATA_W-1:LOW_W]) & $past(wdata_hi_i)));
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && tgt_i == TGT_SET) |=>
      word_o[DATA_W-1:LOW_W] == ($past(word_o[DATA_W-1:LOW_W]) | $past(wdata_hi_i)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && tgt_i != TGT_NONE) |=> $stable(word_o));
endmodule

// File: rtl/misc_rdpath.sv
module misc_rdpath #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              rd_direct_i,
  input  logic              unimpl_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd_en_i && rd_direct_i) rdata_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= rd_en_i;
      rsp_rdata_o <= rdata_d;
      err_o       <= unimpl_i;
    end
  end

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rsp_valid_o);
  assert_rsp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rsp_valid_o);
  assert_alias_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_direct_i) |=> rsp_rdata_o == '0);
  assert_err_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_i |=> err_o);
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !unimpl_i |=> !err_o);
endmodule

// File: rtl/misc_ctl_alias.sv
module misc_ctl_alias
  import misc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned KEEP_W  = 16,
  parameter int unsigned DIR_OFS = 32'h4020,
  parameter int unsigned CLR_OFS = 32'h4021,
  parameter int unsigned SET_OFS = 32'h4022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_unimpl,
  output logic              irq_out
);
  localparam int unsigned WORD_SH = 3;
  localparam int unsigned OFS_W   = ADDR_W - WORD_SH;
  localparam int unsigned LOW_W   = DATA_W - KEEP_W;

  logic              rst_meta_q;
  logic              rst_sync_q;
  tgt_e              tgt;
  logic [DATA_W-1:0] word;
  logic              wr_en;
  logic              rd_en;
  logic              unimpl;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign unused_bits = ^{req_addr[WORD_SH-1:0], req_wdata[LOW_W-1:0]};

  misc_addr_dec #(
    .OFS_W(OFS_W), .DIR_OFS(DIR_OFS), .CLR_OFS(CLR_OFS), .SET_OFS(SET_OFS)
  ) u_dec (
    .ofs_i (req_addr[ADDR_W-1:WORD_SH]),
    .tgt_o (tgt)
  );

  always_comb begin
    wr_en  = req_valid && req_write;
    rd_en  = req_valid && !req_write;
    unimpl = req_valid && (tgt == TGT_NONE);
  end

  misc_store #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_en_i    (wr_en),
    .tgt_i      (tgt),
    .wdata_hi_i (req_wdata[DATA_W-1:LOW_W]),
    .word_o     (word),
    .irq_o      (irq_out)
  );

  misc_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .rd_en_i     (rd_en),
    .rd_direct_i (tgt == TGT_DIRECT),
    .unimpl_i    (unimpl),
    .word_i      (word),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .err_o       (err_unimpl)
  );

  assert_irq_direct_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (wr_en && tgt == TGT_DIRECT) |=> irq_out == $past(req_wdata[DATA_W-1]));
  assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rsp_valid |-> rsp_rdata[LOW_W-1:0] == '0);
endmodule

// File: tb/misc_ctl_alias_bench.sv
module misc_ctl_alias_bench;
  localparam logic [19:0] A_DIR = 20'h20100;
  localparam logic [19:0] A_CLR = 20'h20108;
  localparam logic [19:0] A_SET = 20'h20110;
  localparam logic [19:0] A_BAD = 20'h20118;
  localparam logic [63:0] MASK  = 64'hFFFF_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [19:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        err_unimpl;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_val, m_rd;
  logic        m_rv, m_err;

  always #10 clk = ~clk;

  misc_ctl_alias u_misc_ctl_alias (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_unimpl(err_unimpl), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val = '0; m_rd = '0; m_rv = 1'b0; m_err = 1'b0;
    end else begin
      m_rv = 1'b0; m_err = 1'b0; m_rd = '0;
      if (req_valid) begin
        int ofs;
        ofs = int'(req_addr >> 3);
        m_err = !(ofs == 'h4020 || ofs == 'h4021 || ofs == 'h4022);
        if (!req_write) begin
          m_rv = 1'b1;
          if (ofs == 'h4020) m_rd = m_val;
        end else if (ofs == 'h4020) m_val = req_wdata & MASK;
        else if (ofs == 'h4021)     m_val = m_val & req_wdata & MASK;
        else if (ofs == 'h4022)     m_val = (m_val | req_wdata) & MASK;
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq", {63'd0, irq_out}, {63'd0, m_val[63]});
      chk("R8 rsp_valid", {63'd0, rsp_valid}, {63'd0, m_rv});
      if (m_rv) chk("R8 rdata", rsp_rdata, m_rd);
      chk("R10 err", {63'd0, err_unimpl}, {63'd0, m_err});
    end
  end

  task automatic wr(input logic [19:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic [63:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {63'd0, rsp_valid}, 64'd1);
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7: reset state
    chk("R7 irq", {63'd0, irq_out}, 64'd0);
    chk("R7 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R7 err", {63'd0, err_unimpl}, 64'd0);
    rd(A_DIR, 64'd0, "R7 read");
    // R5: low bits dropped
    wr(A_DIR, '1);
    chk("R6 irq set", {63'd0, irq_out}, 64'd1);
    rd(A_DIR, 64'hFFFF_0000_0000_0000, "R5");
    // R3: AND clears bit 63
    wr(A_CLR, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R6 irq clear", {63'd0, irq_out}, 64'd0);
    rd(A_DIR, 64'h7FFF_0000_0000_0000, "R3");
    // R2: direct overwrite
    wr(A_DIR, 64'h1234_5678_9ABC_DEF0);
    rd(A_DIR, 64'h1234_0000_0000_0000, "R2");
    // R1: low address bits ignored (OR alias with byte offset 5)
    wr(A_SET | 20'h5, 64'h8000_0000_0000_00FF);
    rd(A_DIR, 64'h9234_0000_0000_0000, "R1");
    // R4: OR merge
    wr(A_SET, 64'h0001_0000_0000_0000);
    rd(A_DIR, 64'h9235_0000_0000_0000, "R4");
    wr(A_CLR, 64'h0F0F_FFFF_FFFF_FFFF);
    rd(A_DIR, 64'h0205_0000_0000_0000, "R3 mask");
    // R9 / R10: unimplemented writes
    wr(A_BAD, '1);
    chk("R10 err write", {63'd0, err_unimpl}, 64'd1);
    rd(A_DIR, 64'h0205_0000_0000_0000, "R9");
    wr(20'h00040, '1);
    rd(A_DIR | 20'h7, 64'h0205_0000_0000_0000, "R9 low");
    // R8: alias reads return zero, no error
    rd(A_CLR, 64'd0, "R8 clr read");
    chk("R10 no err", {63'd0, err_unimpl}, 64'd0);
    rd(A_SET, 64'd0, "R8 set read");
    rd(A_BAD, 64'd0, "R8 bad read");
    chk("R10 err read", {63'd0, err_unimpl}, 64'd1);
    // Back-to-back write then read with irq edge
    wr(A_DIR, 64'hC000_0000_0000_0000);
    rd(A_DIR, 64'hC000_0000_0000_0000, "R6 b2b");
    wr(A_CLR, 64'h4000_0000_0000_0000);
    rd(A_DIR, 64'h4000_0000_0000_0000, "R3 b2b");
    wr(A_SET, 64'h8000_0000_0000_0000);
    rd(A_DIR, 64'hC000_0000_0000_0000, "R4 b2b");
    // Randomized stream, compared by the per-clock model
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      case ($urandom_range(4))
        0: a = A_DIR;
        1: a = A_CLR;
        2: a = A_SET;
        3: a = A_BAD;
        default: a = 20'h01230;
      endcase
      a = a | 20'($urandom_range(7));
      if ($urandom_range(5) == 0) @(negedge clk);
      else begin
        req_valid = 1'b1; req_write = $urandom_range(1) == 1;
        req_addr = a; req_wdata = {$urandom, $urandom};
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule